// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Cycle Controller

This block sits between a clocked host and a clockless 16-bit static RAM. The RAM has two chip selects of opposite polarity, one enable per byte lane, a write strobe and an output enable. The host issues one word per request through a ready/request handshake. It supplies a word address, write data and two byte enables, and it gets back read data with a one-cycle valid strobe.

Every memory pin is registered, so each transition falls on a clock edge. The write pulse, data setup, address and output-enable access times and the bus turnaround after a read are parameters counted in clock cycles. The state machine holds each phase for its count. A write lowers the write strobe on the same edge as the selects, so the RAM keeps its outputs off. The controller drives data only while the strobe is low.

Top module: `sram_byte_ctrl`

## Requirements
- R1: While reset is asserted and whenever the controller is idle, the active-low select is high, the active-high select is low, both lane enables, the write strobe and the output enable are high, the data driver is off and `ready_o` is high.
- R2: An accepted write with a nonzero byte enable holds the write strobe low for exactly max(T_WP, T_DS) cycles, starting the cycle after acceptance. During that pulse both selects are active and the lane enables are low only for the requested lanes (bit 0 selects bits 7:0 through `sram_lb_n_o`; bit 1 selects bits 15:8 through `sram_ub_n_o`). The strobe, the selects and the lane enables all return high on the same edge.
- R3: Throughout a write pulse the address and write data on the memory side stay constant and the data driver stays on. The write strobe falls on the same edge as the selects, never after them.
- R4: An accepted read holds the output enable low, the write strobe high, both selects active and the data driver off for exactly max(T_AA, T_OE) cycles, starting the cycle after acceptance. The lane enables follow the byte enables, and both lanes are enabled when the byte enable is zero.
- R5: `rvalid_o` is high for exactly one cycle, the cycle after the read window ends. `rdata_o` then holds the bus value sampled on that edge, with lanes not enabled reading as zero.
- R6: A write with one byte enable set leaves the other byte of the stored word unchanged.
- R7: `ready_o` is high only when the controller is idle. A request is taken on a cycle where `req_i` and `ready_o` are both high.
- R8: A write request with both byte enables clear is taken but produces no write strobe. `ready_o` stays high and the memory contents do not change.
- R9: After a read, the controller stays busy and deselected for T_TURN cycles. The data driver is never enabled within T_TURN cycles of the output enable rising.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Host request |
| ready_o | output | 1 | Controller idle, request can be taken |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Word address |
| wdata_i | input | 16 | Write data |
| be_i | input | 2 | Byte enables, bit 0 = low byte |
| rdata_o | output | 16 | Read data |
| rvalid_o | output | 1 | Read data valid, one cycle |
| sram_addr_o | output | AW | Memory address |
| sram_cs_n_o | output | 1 | Active-low chip select |
| sram_cs_o | output | 1 | Active-high chip select |
| sram_lb_n_o | output | 1 | Low-byte lane enable, active low |
| sram_ub_n_o | output | 1 | High-byte lane enable, active low |
| sram_wr_n_o | output | 1 | Write strobe, active low |
| sram_rd_n_o | output | 1 | Output enable, active low |
| sram_dq_o | output | 16 | Data to memory |
| sram_dq_oe_o | output | 1 | Data driver enable |
| sram_dq_i | input | 16 | Data from memory |

## Verification
Some rules are checked on every cycle: the write strobe is only ever low with both selects and a lane active, and the address and data hold still across a pulse. The output enable never overlaps the write strobe or the data driver, idle means deselected, the valid strobe is a single pulse, and the driver respects the turnaround gap after a read. Only the bench scenarios can show the exact phase lengths, the lane contents after partial writes, the zeroing of disabled lanes in read data, and that a write with no byte enables leaves memory untouched. For these the bench compares against a behavioural model and a model RAM.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  localparam int unsigned DW = 16;
  localparam int unsigned NB = DW / 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_READ  = 2'd2,
    ST_TURN  = 2'd3
  } ctrl_state_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (load_i)     cnt_q <= load_val_i;
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CW      = 4,
  parameter int unsigned WR_LEN  = 3,
  parameter int unsigned RD_LEN  = 4,
  parameter int unsigned TURN    = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [NB-1:0] be_i,
  input  logic [DW-1:0] dq_i,
  input  logic [NB-1:0] lane_en_i,
  input  logic          done_i,
  output logic          ready_o,
  output logic          accept_o,
  output ctrl_state_e   state_d_o,
  output logic          load_o,
  output logic [CW-1:0] load_val_o,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o
);
  localparam logic [CW-1:0] WR_LOAD   = CW'(WR_LEN - 1);
  localparam logic [CW-1:0] RD_LOAD   = CW'(RD_LEN - 1);
  localparam logic [CW-1:0] TURN_LOAD = CW'(TURN - 1);

  ctrl_state_e   state_q, state_d;
  logic          capture;
  logic [DW-1:0] rdata_q, rdata_nxt;
  logic          rvalid_q;

  assign ready_o  = (state_q == ST_IDLE);
  assign accept_o = req_i && ready_o;

  always_comb begin
    state_d    = state_q;
    load_o     = 1'b0;
    load_val_o = '0;
    capture    = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_i) begin
        if (!we_i) begin
          state_d    = ST_READ;
          load_o     = 1'b1;
          load_val_o = RD_LOAD;
        end else if (be_i != '0) begin
          state_d    = ST_WRITE;
          load_o     = 1'b1;
          load_val_o = WR_LOAD;
        end
      end
      ST_WRITE: if (done_i) state_d = ST_IDLE;
      ST_READ: if (done_i) begin
        state_d    = ST_TURN;
        load_o     = 1'b1;
        load_val_o = TURN_LOAD;
        capture    = 1'b1;
      end
      ST_TURN: if (done_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign state_d_o = state_d;

  // lanes not enabled read back as zero
  for (genvar l = 0; l < NB; l++) begin : g_lane
    assign rdata_nxt[l*8 +: 8] = lane_en_i[l] ? dq_i[l*8 +: 8] : 8'h00;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      rvalid_q <= capture;
      if (capture) rdata_q <= rdata_nxt;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
endmodule

// File: rtl/sram_pin_reg.sv
module sram_pin_reg
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned AW = 19
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  ctrl_state_e   state_d_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [NB-1:0] be_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic [NB-1:0] lane_en_o,
  output logic          cs_n_o,
  output logic          cs_o,
  output logic          lb_n_o,
  output logic          ub_n_o,
  output logic          wr_n_o,
  output logic          rd_n_o,
  output logic          dq_oe_o
);
  logic [NB-1:0] lane_q, lane_nxt;
  logic          active_d;

  assign active_d = (state_d_i == ST_WRITE) || (state_d_i == ST_READ);
  assign lane_nxt = !accept_i      ? lane_q :
                    (be_i == '0)   ? {NB{1'b1}} : be_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      wdata_o <= '0;
      lane_q  <= '0;
      cs_n_o  <= 1'b1;
      cs_o    <= 1'b0;
      lb_n_o  <= 1'b1;
      ub_n_o  <= 1'b1;
      wr_n_o  <= 1'b1;
      rd_n_o  <= 1'b1;
      dq_oe_o <= 1'b0;
    end else begin
      if (accept_i) begin
        addr_o  <= addr_i;
        wdata_o <= wdata_i;
      end
      lane_q  <= lane_nxt;
      cs_n_o  <= !active_d;
      cs_o    <= active_d;
      lb_n_o  <= !(active_d && lane_nxt[0]);
      ub_n_o  <= !(active_d && lane_nxt[1]);
      // strobe falls with the selects so the memory never drives during a write
      wr_n_o  <= (state_d_i != ST_WRITE);
      rd_n_o  <= (state_d_i != ST_READ);
      dq_oe_o <= (state_d_i == ST_WRITE);
    end
  end

  assign lane_en_o = lane_q;
endmodule

// File: rtl/sram_byte_ctrl.sv
module sram_byte_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned AW     = 19,
  parameter int unsigned T_WP   = 3,
  parameter int unsigned T_DS   = 2,
  parameter int unsigned T_AA   = 4,
  parameter int unsigned T_OE   = 2,
  parameter int unsigned T_TURN = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  output logic          ready_o,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [15:0]   wdata_i,
  input  logic [1:0]    be_i,
  output logic [15:0]   rdata_o,
  output logic          rvalid_o,
  output logic [AW-1:0] sram_addr_o,
  output logic          sram_cs_n_o,
  output logic          sram_cs_o,
  output logic          sram_lb_n_o,
  output logic          sram_ub_n_o,
  output logic          sram_wr_n_o,
  output logic          sram_rd_n_o,
  output logic [15:0]   sram_dq_o,
  output logic          sram_dq_oe_o,
  input  logic [15:0]   sram_dq_i
);
  localparam int unsigned WR_LEN = max2(T_WP, T_DS);
  localparam int unsigned RD_LEN = max2(T_AA, T_OE);
  localparam int unsigned MAXLEN = max2(max2(WR_LEN, RD_LEN), T_TURN);
  localparam int unsigned CW     = $clog2(MAXLEN + 1);

  ctrl_state_e   state_d;
  logic          accept, load, done;
  logic [CW-1:0] load_val;
  logic [NB-1:0] lane_en;

  sram_phase_timer #(.CW(CW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .done_o     (done)
  );

  sram_ctrl_fsm #(
    .CW(CW), .WR_LEN(WR_LEN), .RD_LEN(RD_LEN), .TURN(T_TURN)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .be_i       (be_i),
    .dq_i       (sram_dq_i),
    .lane_en_i  (lane_en),
    .done_i     (done),
    .ready_o    (ready_o),
    .accept_o   (accept),
    .state_d_o  (state_d),
    .load_o     (load),
    .load_val_o (load_val),
    .rdata_o    (rdata_o),
    .rvalid_o   (rvalid_o)
  );

  sram_pin_reg #(.AW(AW)) u_pins (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .state_d_i (state_d),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .be_i      (be_i),
    .addr_o    (sram_addr_o),
    .wdata_o   (sram_dq_o),
    .lane_en_o (lane_en),
    .cs_n_o    (sram_cs_n_o),
    .cs_o      (sram_cs_o),
    .lb_n_o    (sram_lb_n_o),
    .ub_n_o    (sram_ub_n_o),
    .wr_n_o    (sram_wr_n_o),
    .rd_n_o    (sram_rd_n_o),
    .dq_oe_o   (sram_dq_oe_o)
  );
endmodule

// File: rtl/sram_byte_ctrl_chk.sv
module sram_byte_ctrl_chk #(
  parameter int unsigned AW     = 19,
  parameter int unsigned T_TURN = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          ready_o,
  input logic          we_i,
  input logic [1:0]    be_i,
  input logic          rvalid_o,
  input logic [AW-1:0] sram_addr_o,
  input logic          sram_cs_n_o,
  input logic          sram_cs_o,
  input logic          sram_lb_n_o,
  input logic          sram_ub_n_o,
  input logic          sram_wr_n_o,
  input logic          sram_rd_n_o,
  input logic [15:0]   sram_dq_o,
  input logic          sram_dq_oe_o
);
  localparam int unsigned GMAX = T_TURN + 1;
  localparam int unsigned GW   = $clog2(GMAX + 1);

  logic [GW-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  gap_q <= GW'(GMAX);
    else if (!sram_rd_n_o)        gap_q <= '0;
    else if (gap_q != GW'(GMAX))  gap_q <= gap_q + 1'b1;
  end

  a_r1_idle_pins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (sram_cs_n_o && !sram_cs_o && sram_lb_n_o && sram_ub_n_o &&
                 sram_wr_n_o && sram_rd_n_o && !sram_dq_oe_o));

  a_r2_write_qualified: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_wr_n_o |-> (!sram_cs_n_o && sram_cs_o && (!sram_lb_n_o || !sram_ub_n_o) &&
                      sram_rd_n_o && sram_dq_oe_o));

  a_r3_write_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_wr_n_o && !$past(sram_wr_n_o)) |-> ($stable(sram_addr_o) && $stable(sram_dq_o)));

  a_r4_read_bus_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_rd_n_o |-> (sram_wr_n_o && !sram_dq_oe_o && !sram_cs_n_o && sram_cs_o));

  a_r5_rvalid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o);

  a_r7_accept_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o && (!we_i || be_i != 2'b00)) |=> !ready_o);

  a_r8_noop_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o && we_i && be_i == 2'b00) |=> (ready_o && sram_wr_n_o));

  a_r9_turnaround: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_dq_oe_o |-> (gap_q > GW'(T_TURN)));
endmodule

bind sram_byte_ctrl sram_byte_ctrl_chk #(.AW(AW), .T_TURN(T_TURN)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .ready_o      (ready_o),
  .we_i         (we_i),
  .be_i         (be_i),
  .rvalid_o     (rvalid_o),
  .sram_addr_o  (sram_addr_o),
  .sram_cs_n_o  (sram_cs_n_o),
  .sram_cs_o    (sram_cs_o),
  .sram_lb_n_o  (sram_lb_n_o),
  .sram_ub_n_o  (sram_ub_n_o),
  .sram_wr_n_o  (sram_wr_n_o),
  .sram_rd_n_o  (sram_rd_n_o),
  .sram_dq_o    (sram_dq_o),
  .sram_dq_oe_o (sram_dq_oe_o)
);

// File: tb/sram_byte_ctrl_tb.sv
`timescale 1ns/1ps
module sram_byte_ctrl_tb;
  localparam int AW = 19, T_WP = 3, T_DS = 2, T_AA = 4, T_OE = 2, T_TURN = 2;
  localparam int WR_LEN = 3, RD_LEN = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_i = 1'b0, we_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [1:0] be_i = '0;
  logic ready_o, rvalid_o;
  logic [15:0] rdata_o;
  logic [AW-1:0] sram_addr_o;
  logic sram_cs_n_o, sram_cs_o, sram_lb_n_o, sram_ub_n_o, sram_wr_n_o, sram_rd_n_o, sram_dq_oe_o;
  logic [15:0] sram_dq_o, sram_dq_i;

  always #2.5 clk_i = ~clk_i;

  sram_byte_ctrl #(.AW(AW), .T_WP(T_WP), .T_DS(T_DS), .T_AA(T_AA), .T_OE(T_OE), .T_TURN(T_TURN)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .ready_o(ready_o), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .be_i(be_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o),
    .sram_addr_o(sram_addr_o), .sram_cs_n_o(sram_cs_n_o), .sram_cs_o(sram_cs_o),
    .sram_lb_n_o(sram_lb_n_o), .sram_ub_n_o(sram_ub_n_o), .sram_wr_n_o(sram_wr_n_o),
    .sram_rd_n_o(sram_rd_n_o), .sram_dq_o(sram_dq_o), .sram_dq_oe_o(sram_dq_oe_o),
    .sram_dq_i(sram_dq_i));

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  // model RAM driven only by the pins
  logic [15:0] ram_mem [0:63];
  wire ram_sel = !sram_cs_n_o && sram_cs_o && (!sram_lb_n_o || !sram_ub_n_o);
  always_comb begin
    if (ram_sel && sram_wr_n_o && !sram_rd_n_o)
      sram_dq_i = {sram_ub_n_o ? 8'h00 : ram_mem[sram_addr_o[5:0]][15:8],
                   sram_lb_n_o ? 8'h00 : ram_mem[sram_addr_o[5:0]][7:0]};
    else
      sram_dq_i = 16'h0000;
  end
  always @(posedge clk_i) begin
    if (ram_sel && !sram_wr_n_o) begin
      if (!sram_lb_n_o) ram_mem[sram_addr_o[5:0]][7:0]  <= sram_dq_o[7:0];
      if (!sram_ub_n_o) ram_mem[sram_addr_o[5:0]][15:8] <= sram_dq_o[15:8];
    end
  end

  // behavioural reference: phase 0 idle, 1 write, 2 read, 3 turnaround
  logic [15:0] ref_mem [0:63];
  int ph = 0, left = 0;
  logic [AW-1:0] m_addr = '0;
  logic [15:0] m_wdata = '0, e_rdata = '0;
  logic [1:0] m_lane = '0;
  logic e_rvalid = 1'b0;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      ph = 0; left = 0; e_rvalid = 1'b0; m_lane = '0;
    end else begin
      e_rvalid = 1'b0;
      case (ph)
        0: if (req_i) begin
          m_addr = addr_i; m_wdata = wdata_i;
          m_lane = (be_i == 2'b00) ? 2'b11 : be_i;
          if (!we_i) begin ph = 2; left = RD_LEN; end
          else if (be_i != 2'b00) begin
            ph = 1; left = WR_LEN;
            if (be_i[0]) ref_mem[addr_i[5:0]][7:0]  = wdata_i[7:0];
            if (be_i[1]) ref_mem[addr_i[5:0]][15:8] = wdata_i[15:8];
          end
        end
        1: begin left--; if (left == 0) ph = 0; end
        2: begin
          left--;
          if (left == 0) begin
            e_rvalid = 1'b1;
            e_rdata = {m_lane[1] ? ref_mem[m_addr[5:0]][15:8] : 8'h00,
                       m_lane[0] ? ref_mem[m_addr[5:0]][7:0]  : 8'h00};
            ph = 3; left = T_TURN;
          end
        end
        default: begin left--; if (left == 0) ph = 0; end
      endcase
    end
  end

  int gap = 100;
  always @(negedge clk_i) begin
    logic act, e_lb_n, e_ub_n;
    act = (ph == 1) || (ph == 2);
    e_lb_n = !(act && m_lane[0]);
    e_ub_n = !(act && m_lane[1]);
    if (rst_ni) begin
      chk("R7", "ready", ready_o, ph == 0);
      if (ph == 1)
        chk("R2", "write pins", {sram_cs_n_o, sram_cs_o, sram_lb_n_o, sram_ub_n_o, sram_wr_n_o, sram_rd_n_o, sram_dq_oe_o},
            {1'b0, 1'b1, e_lb_n, e_ub_n, 1'b0, 1'b1, 1'b1});
      else if (ph == 2)
        chk("R4", "read pins", {sram_cs_n_o, sram_cs_o, sram_lb_n_o, sram_ub_n_o, sram_wr_n_o, sram_rd_n_o, sram_dq_oe_o},
            {1'b0, 1'b1, e_lb_n, e_ub_n, 1'b1, 1'b0, 1'b0});
      else
        chk("R1", "idle pins", {sram_cs_n_o, sram_cs_o, sram_lb_n_o, sram_ub_n_o, sram_wr_n_o, sram_rd_n_o, sram_dq_oe_o},
            7'b1011110);
      if (act) chk("R3", "address", sram_addr_o, m_addr);
      if (ph == 1) chk("R3", "write data", sram_dq_o, m_wdata);
      chk("R5", "rvalid", rvalid_o, e_rvalid);
      if (e_rvalid) chk("R5", "rdata", rdata_o, e_rdata);
      if (!sram_rd_n_o) gap = 0; else if (gap < 100) gap++;
      if (sram_dq_oe_o) chk("R9", "turnaround gap ok", gap > T_TURN, 1);
    end
  end

  task automatic issue(input logic we, input logic [AW-1:0] a, input logic [15:0] d, input logic [1:0] be);
    while (!ready_o) @(negedge clk_i);
    req_i = 1'b1; we_i = we; addr_i = a; wdata_i = d; be_i = be;
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [1:0] be, input logic [15:0] exp, input string req);
    issue(1'b0, a, 16'h0, be);
    while (!rvalid_o) @(negedge clk_i);
    chk(req, "read back", rdata_o, exp);
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(50000 * 5);
    n_fail++;
    $display("FAIL R7 watchdog: actual hung expected done");
    summary();
  end

  initial begin
    for (int i = 0; i < 64; i++) begin ram_mem[i] = 16'h0000; ref_mem[i] = 16'h0000; end
    repeat (3) @(negedge clk_i);
    chk("R1", "reset pins", {sram_cs_n_o, sram_cs_o, sram_lb_n_o, sram_ub_n_o, sram_wr_n_o, sram_rd_n_o, sram_dq_oe_o, ready_o},
        8'b10111101);
    rst_ni = 1'b1;
    @(negedge clk_i);
    issue(1'b1, 19'd5, 16'h1234, 2'b11);
    rd(19'd5, 2'b11, 16'h1234, "R2");
    issue(1'b1, 19'd5, 16'hABCD, 2'b01);
    rd(19'd5, 2'b11, 16'h12CD, "R6");
    issue(1'b1, 19'd5, 16'h7755, 2'b10);
    rd(19'd5, 2'b11, 16'h77CD, "R6");
    rd(19'd5, 2'b01, 16'h00CD, "R5");
    rd(19'd5, 2'b10, 16'h7700, "R5");
    issue(1'b1, 19'd5, 16'hFFFF, 2'b00);
    chk("R8", "ready after noop", ready_o, 1'b1);
    chk("R8", "strobe after noop", sram_wr_n_o, 1'b1);
    rd(19'd5, 2'b00, 16'h77CD, "R8");
    issue(1'b1, 19'h7FFC1, 16'hC0DE, 2'b11);
    issue(1'b1, 19'd40, 16'h5AA5, 2'b11);
    rd(19'h7FFC1, 2'b11, 16'hC0DE, "R4");
    issue(1'b1, 19'd40, 16'h0F0F, 2'b01);
    rd(19'd40, 2'b11, 16'h5A0F, "R9");
    for (int i = 0; i < 8; i++) begin
      issue(1'b1, 19'(i + 8), 16'(i * 16'h1111), 2'(i % 4));
      issue(1'b0, 19'(i + 8), 16'h0, 2'b11);
    end
    repeat (12) @(negedge clk_i);
    chk("R6", "model ram word 40", ram_mem[40], 16'h5A0F);
    chk("R8", "model ram word 8", ram_mem[8], 16'h0000);
    summary();
  end
endmodule